// File: doc/BRIEF.md
# Accumulator Shift, Rotate and Micro-Op Skip Unit

This unit carries out one register-reference instruction on a chosen 16-bit accumulator (A or B) and the 1-bit extend flag E. The instruction word, both accumulators and E arrive together with a valid strobe. One clock edge later the unit presents the new A, B and E values and a skip request that the program counter logic uses to step over the next instruction. Fetch and counter update belong to the surrounding processor.

Two instruction groups are decoded. The shift group has two independently enabled 3-bit shift fields. Between them sit an optional clear of E and an optional skip test on the low bit of the register. The micro-op group applies clear, complement, E manipulation, increment and four skip tests in a fixed left-to-right order. An optional reverse-sense bit inverts how the selected tests combine into the skip.

Top module: `rsu_top`

## Requirements
- R1: Instruction bit 11 chooses the working register (0 = A, 1 = B). The register that is not chosen leaves the unit with its input value.
- R2: Bit 10 = 0 selects the shift group. Bit 9 enables the first shift field (bits 8..6) and bit 4 enables the second field (bits 2..0). A disabled field leaves the register and E untouched, so with both fields disabled and bit 5 clear the register and E pass through unchanged.
- R3: The shift field codes are: 000 shift left one with a zero in; 001 shift right one with a zero in; 010 rotate left one; 011 rotate right one; 100 shift left one then force bit 15 to 0; 101 rotate right through E (bit 0 to E, E to bit 15); 110 rotate left through E (bit 15 to E, E to bit 0); 111 rotate left four. Only codes 101 and 110 alter E.
- R4: In the shift group the first field acts first. Then bit 5 = 1 clears E. Then the second field acts on the result.
- R5: In the shift group, bit 3 = 1 requests a skip exactly when bit 0 of the register is 0 after the first field and before the second. With bit 3 = 0 no skip is requested.
- R6: Bit 10 = 1 selects the micro-op group. Bit 9 clears the register, bit 8 complements it and bit 2 increments it modulo 2^16, applied in the order clear, complement, increment.
- R7: In the micro-op group bit 6 clears E and bit 5 complements E, clear first. Both set therefore give E = 1.
- R8: The micro-op tests are bit 4 (E is 0), bit 3 (register bit 15 is 0), bit 1 (register bit 0 is 0) and bit 0 (register is zero). Each test sees the values at its place in the order: clear, complement, E-zero test, clear E, complement E, sign test, low-bit test, increment, zero test.
- R9: With bit 7 = 0 the unit skips if any selected test is true. With bit 7 = 1 it skips only if every selected test is false, so bit 7 with no tests always skips.
- R10: Results, skip and a valid pulse appear on the clock edge that samples the input strobe. Without a strobe the result outputs hold their values and the valid output is 0. Synchronous reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 16 | Register-reference instruction word |
| a_in | input | 16 | Current A accumulator |
| b_in | input | 16 | Current B accumulator |
| e_in | input | 1 | Current extend flag |
| out_valid | output | 1 | Result registered from the previous strobe |
| a_out | output | 16 | Updated A accumulator |
| b_out | output | 16 | Updated B accumulator |
| e_out | output | 1 | Updated extend flag |
| skip_out | output | 1 | Request to skip the next instruction |

## Verification
The properties assume that the instruction and operand inputs are stable and meaningful only in a cycle where the strobe is high, and that the caller never drives the strobe during reset. The bench drives inputs at the falling edge, raises the strobe for exactly one cycle per instruction and holds it low otherwise. This way every past-value comparison refers to a real instruction. Bits 15..12 are always driven to zero, since only the register-reference subset is in the unit's scope.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
    localparam int WORD_W = 16;
    localparam int FLD_W  = 3;
    localparam int NIB_W  = 4;

    typedef enum logic [FLD_W-1:0] {
        SH_LSL  = 3'd0,
        SH_LSR  = 3'd1,
        SH_ROL  = 3'd2,
        SH_ROR  = 3'd3,
        SH_LSLC = 3'd4,
        SH_RRE  = 3'd5,
        SH_RLE  = 3'd6,
        SH_RL4  = 3'd7
    } shift_op_e;

    typedef struct packed {
        logic              e;
        logic [WORD_W-1:0] r;
    } acc_state_t;

    typedef struct packed {
        logic clr_r;
        logic cmp_r;
        logic rev;
        logic clr_e;
        logic cmp_e;
        logic t_ez;
        logic t_pos;
        logic inc_r;
        logic t_lsb;
        logic t_zero;
    } alter_ctl_t;

    function automatic acc_state_t shift_one(shift_op_e op, acc_state_t s);
        acc_state_t n;
        n = s;
        case (op)
            SH_LSL:  n.r = {s.r[WORD_W-2:0], 1'b0};
            SH_LSR:  n.r = {1'b0, s.r[WORD_W-1:1]};
            SH_ROL:  n.r = {s.r[WORD_W-2:0], s.r[WORD_W-1]};
            SH_ROR:  n.r = {s.r[0], s.r[WORD_W-1:1]};
            SH_LSLC: n.r = {1'b0, s.r[WORD_W-3:0], 1'b0};
            SH_RRE: begin
                n.r = {s.e, s.r[WORD_W-1:1]};
                n.e = s.r[0];
            end
            SH_RLE: begin
                n.r = {s.r[WORD_W-2:0], s.e};
                n.e = s.r[WORD_W-1];
            end
            default: n.r = {s.r[WORD_W-NIB_W-1:0], s.r[WORD_W-1:WORD_W-NIB_W]};
        endcase
        return n;
    endfunction

    function automatic alter_ctl_t decode_alter(logic [WORD_W-1:0] ir);
        alter_ctl_t c;
        c.clr_r  = ir[9];
        c.cmp_r  = ir[8];
        c.rev    = ir[7];
        c.clr_e  = ir[6];
        c.cmp_e  = ir[5];
        c.t_ez   = ir[4];
        c.t_pos  = ir[3];
        c.inc_r  = ir[2];
        c.t_lsb  = ir[1];
        c.t_zero = ir[0];
        return c;
    endfunction
endpackage

// File: rtl/rsu_shift_stage.sv
module rsu_shift_stage
    import rsu_pkg::*;
(
    input  logic       en,
    input  shift_op_e  op,
    input  acc_state_t st_in,
    output acc_state_t st_out
);
    always_comb begin
        st_out = en ? shift_one(op, st_in) : st_in;
    end
endmodule

// File: rtl/rsu_shift_group.sv
module rsu_shift_group
    import rsu_pkg::*;
#(
    parameter int N_STAGE = 2
) (
    input  logic [WORD_W-1:0] ir,
    input  acc_state_t        st_in,
    output acc_state_t        st_out,
    output logic              skip
);
    acc_state_t stage_in  [N_STAGE];
    acc_state_t stage_out [N_STAGE];
    logic       stage_en  [N_STAGE];
    shift_op_e  stage_op  [N_STAGE];

    assign stage_en[0] = ir[9];
    assign stage_op[0] = shift_op_e'(ir[8:6]);
    assign stage_en[1] = ir[4];
    assign stage_op[1] = shift_op_e'(ir[2:0]);

    always_comb begin
        stage_in[0] = st_in;
        stage_in[1] = stage_out[0];
        if (ir[5]) stage_in[1].e = 1'b0;
    end

    assign skip = ir[3] & ~stage_out[0].r[0];

    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        rsu_shift_stage u_stage (
            .en     (stage_en[g]),
            .op     (stage_op[g]),
            .st_in  (stage_in[g]),
            .st_out (stage_out[g])
        );
    end

    assign st_out = stage_out[N_STAGE-1];
endmodule

// File: rtl/rsu_alter_group.sv
module rsu_alter_group
    import rsu_pkg::*;
(
    input  logic [WORD_W-1:0] ir,
    input  acc_state_t        st_in,
    output acc_state_t        st_out,
    output logic              skip
);
    alter_ctl_t ctl;
    assign ctl = decode_alter(ir);

    always_comb begin
        logic [WORD_W-1:0] r;
        logic              e;
        logic              hit;
        r   = st_in.r;
        e   = st_in.e;
        hit = 1'b0;
        if (ctl.clr_r) r = '0;
        if (ctl.cmp_r) r = ~r;
        if (ctl.t_ez)  hit = hit | ~e;
        if (ctl.clr_e) e = 1'b0;
        if (ctl.cmp_e) e = ~e;
        if (ctl.t_pos) hit = hit | ~r[WORD_W-1];
        if (ctl.t_lsb) hit = hit | ~r[0];
        if (ctl.inc_r) r = r + 1'b1;
        if (ctl.t_zero) hit = hit | (r == '0);
        st_out.r = r;
        st_out.e = e;
        skip     = ctl.rev ? ~hit : hit;
    end
endmodule

// File: rtl/rsu_top.sv
module rsu_top
    import rsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic              e_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] a_out,
    output logic [WORD_W-1:0] b_out,
    output logic              e_out,
    output logic              skip_out
);
    acc_state_t sel_st, sh_st, al_st, res_st;
    logic       sh_skip, al_skip, res_skip;
    logic       use_b, use_alter;

    assign use_b     = instr[11];
    assign use_alter = instr[10];

    assign sel_st.r = use_b ? b_in : a_in;
    assign sel_st.e = e_in;

    rsu_shift_group #(.N_STAGE(2)) u_shift (
        .ir     (instr),
        .st_in  (sel_st),
        .st_out (sh_st),
        .skip   (sh_skip)
    );

    rsu_alter_group u_alter (
        .ir     (instr),
        .st_in  (sel_st),
        .st_out (al_st),
        .skip   (al_skip)
    );

    assign res_st   = use_alter ? al_st : sh_st;
    assign res_skip = use_alter ? al_skip : sh_skip;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            a_out     <= '0;
            b_out     <= '0;
            e_out     <= 1'b0;
            skip_out  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                a_out    <= use_b ? a_in : res_st.r;
                b_out    <= use_b ? res_st.r : b_in;
                e_out    <= res_st.e;
                skip_out <= res_skip;
            end
        end
    end
endmodule

// File: rtl/rsu_chk.sv
module rsu_chk
    import rsu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] instr,
    input logic [WORD_W-1:0] a_in,
    input logic [WORD_W-1:0] b_in,
    input logic              e_in,
    input logic              out_valid,
    input logic [WORD_W-1:0] a_out,
    input logic [WORD_W-1:0] b_out,
    input logic              e_out,
    input logic              skip_out
);
    AST_KEEP_A: assert property (@(posedge clk) disable iff (rst)
        in_valid && instr[11] |=> a_out == $past(a_in)); // R1
    AST_KEEP_B: assert property (@(posedge clk) disable iff (rst)
        in_valid && !instr[11] |=> b_out == $past(b_in)); // R1
    AST_SHIFT_NOP: assert property (@(posedge clk) disable iff (rst)
        in_valid && !instr[10] && !instr[9] && !instr[4] && !instr[5]
        |=> (($past(instr[11]) ? b_out == $past(b_in) : a_out == $past(a_in))
             && e_out == $past(e_in))); // R2
    AST_SHIFT_NO_TEST: assert property (@(posedge clk) disable iff (rst)
        in_valid && !instr[10] && !instr[3] |=> !skip_out); // R5
    AST_E_CLR_CMP: assert property (@(posedge clk) disable iff (rst)
        in_valid && instr[10] && instr[6] && instr[5] |=> e_out); // R7
    AST_REV_ALONE: assert property (@(posedge clk) disable iff (rst)
        in_valid && instr[10] && instr[7] && instr[4:3] == 2'b00 && instr[1:0] == 2'b00
        |=> skip_out); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(a_out) && $stable(b_out)
                      && $stable(e_out) && $stable(skip_out)); // R10
endmodule

bind rsu_top rsu_chk u_chk (.*);

// File: tb/sim_rsu_top.sv
module sim_rsu_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic        e_in = 1'b0;
    logic        out_valid;
    logic [15:0] a_out, b_out;
    logic        e_out, skip_out;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    rsu_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .a_in(a_in), .b_in(b_in), .e_in(e_in), .out_valid(out_valid),
        .a_out(a_out), .b_out(b_out), .e_out(e_out), .skip_out(skip_out)
    );

    task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // shift group word: sel, en1, f1, cle, en2, sla, f2
    function automatic logic [15:0] sh_w(logic sel, logic en1, logic [2:0] f1,
                                         logic cle, logic en2, logic sla, logic [2:0] f2);
        return {4'b0, sel, 1'b0, en1, f1, cle, en2, sla, f2};
    endfunction

    // micro-op word: sel, clr9 cmp8 rss7 cle6 cme5 sez4 ssa3 inc2 sla1 sza0
    function automatic logic [15:0] al_w(logic sel, logic [9:0] ops);
        return {4'b0, sel, 1'b1, ops};
    endfunction

    task automatic run(logic [15:0] w, logic [15:0] a, logic [15:0] b, logic e);
        @(negedge clk);
        instr = w; a_in = a; b_in = b; e_in = e; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_res(string tag, logic [15:0] ea, logic [15:0] eb, logic ee, logic es);
        check(tag, "valid", {15'b0, out_valid}, 16'd1);
        check(tag, "A", a_out, ea);
        check(tag, "B", b_out, eb);
        check(tag, "E", {15'b0, e_out}, {15'b0, ee});
        check(tag, "skip", {15'b0, skip_out}, {15'b0, es});
    endtask

    task automatic t_reset();
        check("R10", "reset valid", {15'b0, out_valid}, 16'd0);
        check("R10", "reset A", a_out, 16'h0);
        check("R10", "reset B", b_out, 16'h0);
        check("R10", "reset E/skip", {14'b0, e_out, skip_out}, 16'h0);
    endtask

    task automatic t_select_nop();
        run(sh_w(0, 0, 3'd3, 0, 0, 0, 3'd3), 16'h1234, 16'h5678, 1); // R2 both disabled
        expect_res("R2", 16'h1234, 16'h5678, 1, 0);
        run(sh_w(1, 1, 3'd2, 0, 0, 0, 3'd0), 16'hAAAA, 16'h8001, 0); // R1 B rotate left
        expect_res("R1", 16'hAAAA, 16'h0003, 0, 0);
    endtask

    task automatic t_codes();
        logic [15:0] exp_r [8];
        logic        exp_e [8];
        exp_r[0] = 16'h814A; exp_e[0] = 0;
        exp_r[1] = 16'h6052; exp_e[1] = 0;
        exp_r[2] = 16'h814B; exp_e[2] = 0;
        exp_r[3] = 16'hE052; exp_e[3] = 0;
        exp_r[4] = 16'h014A; exp_e[4] = 0;
        exp_r[5] = 16'h6052; exp_e[5] = 1;
        exp_r[6] = 16'h814A; exp_e[6] = 1;
        exp_r[7] = 16'h0A5C; exp_e[7] = 0;
        for (int k = 0; k < 8; k++) begin
            run(sh_w(0, 1, 3'(k), 0, 0, 0, 3'd0), 16'hC0A5, 16'h0F0F, 0); // R3 field one
            expect_res("R3", exp_r[k], 16'h0F0F, exp_e[k], 0);
        end
        run(sh_w(1, 0, 3'd0, 0, 1, 0, 3'd7), 16'h1111, 16'hC0A5, 0); // R3 field two on B
        expect_res("R3", 16'h1111, 16'h0A5C, 0, 0);
    endtask

    task automatic t_order();
        run(sh_w(0, 1, 3'd2, 1, 1, 0, 3'd5), 16'h8000, 16'h0, 1); // R4 RL, clr E, ER
        expect_res("R4", 16'h0000, 16'h0, 1, 0);
    endtask

    task automatic t_shift_skip();
        run(sh_w(0, 1, 3'd3, 0, 1, 1, 3'd3), 16'h0002, 16'h0, 0); // R5 tested mid
        expect_res("R5", 16'h8000, 16'h0, 0, 0);
        run(sh_w(0, 1, 3'd1, 0, 1, 1, 3'd2), 16'h0001, 16'h0, 0); // R5 low bit zero
        expect_res("R5", 16'h0000, 16'h0, 0, 1);
        run(sh_w(0, 1, 3'd1, 0, 0, 0, 3'd0), 16'h0004, 16'h0, 0); // R5 no test
        expect_res("R5", 16'h0002, 16'h0, 0, 0);
    endtask

    task automatic t_alter_reg();
        run(al_w(1, 10'b11_0000_0101), 16'h7777, 16'h1234, 0); // R6 clr,cmp,inc wrap, sza
        expect_res("R6", 16'h7777, 16'h0000, 0, 1);
        run(al_w(0, 10'b01_0000_0000), 16'h00FF, 16'h1, 0); // R6 complement
        expect_res("R6", 16'hFF00, 16'h1, 0, 0);
        run(al_w(0, 10'b00_0000_0100), 16'h7FFF, 16'h1, 0); // R6 increment
        expect_res("R6", 16'h8000, 16'h1, 0, 0);
    endtask

    task automatic t_alter_e();
        run(al_w(0, 10'b00_0110_0000), 16'h5, 16'h6, 0); // R7 clr then cmp
        expect_res("R7", 16'h5, 16'h6, 1, 0);
        run(al_w(0, 10'b00_0100_0000), 16'h5, 16'h6, 1); // R7 clr
        expect_res("R7", 16'h5, 16'h6, 0, 0);
        run(al_w(0, 10'b00_0010_0000), 16'h5, 16'h6, 1); // R7 cmp
        expect_res("R7", 16'h5, 16'h6, 0, 0);
    endtask

    task automatic t_test_points();
        run(al_w(0, 10'b00_0011_0000), 16'h5, 16'h0, 0); // R8 E test before cme
        expect_res("R8", 16'h5, 16'h0, 1, 1);
        run(al_w(0, 10'b00_0101_0000), 16'h5, 16'h0, 1); // R8 E test before cle
        expect_res("R8", 16'h5, 16'h0, 0, 0);
        run(al_w(0, 10'b00_0000_1100), 16'hFFFF, 16'h0, 0); // R8 sign before inc
        expect_res("R8", 16'h0000, 16'h0, 0, 0);
        run(al_w(0, 10'b00_0000_0110), 16'h0001, 16'h0, 0); // R8 low bit before inc
        expect_res("R8", 16'h0002, 16'h0, 0, 0);
        run(al_w(0, 10'b10_0000_0001), 16'h0005, 16'h0, 0); // R8 zero after clear
        expect_res("R8", 16'h0000, 16'h0, 0, 1);
    endtask

    task automatic t_sense();
        run(al_w(0, 10'b00_1000_0000), 16'h0009, 16'h3, 1); // R9 reverse alone
        expect_res("R9", 16'h0009, 16'h3, 1, 1);
        run(al_w(0, 10'b00_1000_0001), 16'h0000, 16'h3, 0); // R9 reverse, test true
        expect_res("R9", 16'h0000, 16'h3, 0, 0);
        run(al_w(0, 10'b00_1000_0011), 16'h0003, 16'h3, 0); // R9 reverse, all false
        expect_res("R9", 16'h0003, 16'h3, 0, 1);
        run(al_w(0, 10'b00_0000_0011), 16'h0002, 16'h3, 0); // R9 any true
        expect_res("R9", 16'h0002, 16'h3, 0, 1);
        run(al_w(0, 10'b00_1000_0011), 16'h0002, 16'h3, 0); // R9 reverse, one true
        expect_res("R9", 16'h0002, 16'h3, 0, 0);
    endtask

    task automatic t_hold();
        @(negedge clk);
        instr = al_w(0, 10'b10_0000_0000); a_in = 16'hBEEF; b_in = 16'hCAFE;
        @(negedge clk);
        check("R10", "idle valid", {15'b0, out_valid}, 16'd0);
        check("R10", "idle A hold", a_out, 16'h0002);
        check("R10", "idle B hold", b_out, 16'h0003);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_select_nop();
        t_codes();
        t_order();
        t_shift_skip();
        t_alter_reg();
        t_alter_e();
        t_test_points();
        t_sense();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule